// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block chooses, every cycle, where the two ALU operands of a five-stage integer pipeline come from. It compares the source register numbers of the instruction in the execute stage with the destination registers of the two older instructions still in flight. One of those older instructions has just finished execute. The other is about to write back. When an older instruction is going to write a register that the execute stage reads, the block selects that result in place of the stale register file value. When both older instructions target the same register, the newer result wins.

A second pair of selects serves an equality comparator for branches in the decode stage. When the decoded instruction is a branch and the instruction that has just left execute writes one of its source registers, that result is selected into the comparator. Results in the write-back stage need no path to the comparator. The register file writes in the first half of the cycle and is read in the second, so the comparator already sees them.

The block has no clock or state. The operand multiplexers and the register file belong to the surrounding datapath. Stall insertion and memory-to-memory forwarding are handled elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: Each ALU select `fwdA`/`fwdB` uses the code 2'b00 for the register file value, 2'b10 for the result leaving execute (memory stage) and 2'b01 for the result in write-back. The code 2'b11 never appears.
- R2: `fwdA` is 2'b10 when `memRegWrite` is 1, `memRd` is nonzero and `memRd` equals `exRs`.
- R3: `fwdB` follows the same rule against `exRt`. It is computed independently of `fwdA`, so both may forward in the same cycle, from the same stage or from different stages.
- R4: An ALU select is 2'b01 when `wbRegWrite` is 1, `wbRd` is nonzero, `wbRd` equals that operand's source, and the memory-stage forward for that operand is not taken.
- R5: When both the memory stage and write-back forward conditions hold for one operand, the select is 2'b10.
- R6: A memory-stage destination that matches a source but has `memRegWrite` at 0 does not block a valid write-back forward. The select is then 2'b01.
- R7: A destination of register 0 never produces a forward on any of the four selects.
- R8: `fwdC` (for `idRs`) and `fwdD` (for `idRt`) are 1 when `idBranch` is 1, `memRd` is nonzero and `memRd` equals that source. This holds whatever the value of `memRegWrite`.
- R9: `fwdC` and `fwdD` are 0 when `idBranch` is 0. The write-back destination never affects them.
- R10: For three back-to-back adds that each read and write register 1, the third add sees `fwdA` = 2'b10. The operand it receives is the second add's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRs | input | REG_W | First source register of the execute-stage instruction |
| exRt | input | REG_W | Second source register of the execute-stage instruction |
| memRd | input | REG_W | Destination register held in the memory-stage pipeline register |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | REG_W | Destination register held in the write-back pipeline register |
| wbRegWrite | input | 1 | Write-back instruction writes a register |
| idRs | input | REG_W | First source register of the decode-stage instruction |
| idRt | input | REG_W | Second source register of the decode-stage instruction |
| idBranch | input | 1 | Decode-stage instruction is a conditional branch |
| fwdA | output | 2 | Source select for ALU operand A |
| fwdB | output | 2 | Source select for ALU operand B |
| fwdC | output | 1 | Forward memory-stage result into comparator input for idRs |
| fwdD | output | 1 | Forward memory-stage result into comparator input for idRt |

## Verification
Random register numbers are drawn from a narrow range, so that matches, double matches and register 0 are frequent. Write enables and the branch flag are also random, and all four selects are compared against a model written from the requirements. Directed cases pick out what random traffic might hit only rarely:
- both stages writing the same register, which separates the priority rule from the plain match rule;
- a non-writing memory-stage instruction over a valid write-back, which shows whether the suppression keys on the actual forward;
- register 0 as the destination;
- a branch whose producer has its write enable low;
- the three-add chain, with its operand value taken through a bench multiplexer.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WB      = 2'b01,
    SRC_MEM     = 2'b10
  } opSrc_e;

  // strobes from the comparator datapath to the select control
  typedef struct packed {
    logic memRs;
    logic memRt;
    logic wbRs;
    logic wbRt;
    logic brRs;
    logic brRt;
  } hitStrobes_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic             idBranch,
  output hitStrobes_t      hits
);

  localparam int NUM_SRC = 2;

  logic [REG_W-1:0] exSrc [NUM_SRC];
  logic [REG_W-1:0] idSrc [NUM_SRC];
  logic [NUM_SRC-1:0] memHit;
  logic [NUM_SRC-1:0] wbHit;
  logic [NUM_SRC-1:0] brHit;

  logic memLive;
  logic wbLive;
  logic memNonZero;

  assign exSrc[0] = exRs;
  assign exSrc[1] = exRt;
  assign idSrc[0] = idRs;
  assign idSrc[1] = idRt;

  assign memNonZero = (memRd != '0);
  assign memLive    = memRegWrite && memNonZero;
  assign wbLive     = wbRegWrite && (wbRd != '0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign memHit[i] = memLive && (memRd == exSrc[i]);
    assign wbHit[i]  = wbLive && (wbRd == exSrc[i]);
    // branch compare path keys on destination only, not on the write enable
    assign brHit[i]  = idBranch && memNonZero && (memRd == idSrc[i]);
  end

  assign hits = '{
    memRs: memHit[0],
    memRt: memHit[1],
    wbRs:  wbHit[0],
    wbRt:  wbHit[1],
    brRs:  brHit[0],
    brRt:  brHit[1]
  };

  always_comb begin
    assert_zero_dest_R7: assert (!((memRd == '0) && (hits.memRs || hits.memRt || hits.brRs || hits.brRt)));
  end

endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
(
  input  hitStrobes_t hits,
  output opSrc_e      selA,
  output opSrc_e      selB,
  output logic        selC,
  output logic        selD
);

  function automatic opSrc_e pickSrc(input logic memHit, input logic wbHit);
    if (memHit)     return SRC_MEM;
    else if (wbHit) return SRC_WB;
    else            return SRC_REGFILE;
  endfunction

  assign selA = pickSrc(hits.memRs, hits.wbRs);
  assign selB = pickSrc(hits.memRt, hits.wbRt);
  assign selC = hits.brRs;
  assign selD = hits.brRt;

  always_comb begin
    assert_newest_wins_R5: assert (!(hits.memRs && hits.wbRs) || selA == SRC_MEM);
    assert_newest_wins_b_R5: assert (!(hits.memRt && hits.wbRt) || selB == SRC_MEM);
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic             idBranch,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB,
  output logic             fwdC,
  output logic             fwdD
);

  hitStrobes_t hits;
  opSrc_e      selA;
  opSrc_e      selB;

  fwd_match #(.REG_W(REG_W)) u_match (
    .exRs        (exRs),
    .exRt        (exRt),
    .memRd       (memRd),
    .memRegWrite (memRegWrite),
    .wbRd        (wbRd),
    .wbRegWrite  (wbRegWrite),
    .idRs        (idRs),
    .idRt        (idRt),
    .idBranch    (idBranch),
    .hits        (hits)
  );

  fwd_select u_select (
    .hits (hits),
    .selA (selA),
    .selB (selB),
    .selC (fwdC),
    .selD (fwdD)
  );

  assign fwdA = selA;
  assign fwdB = selB;

  always_comb begin
    assert_legal_code_R1: assert (fwdA != 2'b11 && fwdB != 2'b11);
    assert_mem_cause_R2: assert (fwdA != 2'b10 || (memRegWrite && memRd != '0 && memRd == exRs));
    assert_wb_cause_R4: assert (fwdA != 2'b01 || (wbRegWrite && wbRd != '0 && wbRd == exRs));
    assert_branch_gate_R9: assert (idBranch || !(fwdC || fwdD));
    assert_branch_cause_R8: assert (!fwdD || (memRd != '0 && memRd == idRt));
  end

endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;

  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [REG_W-1:0] exRs, exRt, memRd, wbRd, idRs, idRt;
  logic memRegWrite, wbRegWrite, idBranch;
  logic [1:0] fwdA, fwdB;
  logic fwdC, fwdD;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fwd_unit #(.REG_W(REG_W)) u_dut (
    .exRs(exRs), .exRt(exRt), .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite), .idRs(idRs), .idRt(idRt),
    .idBranch(idBranch), .fwdA(fwdA), .fwdB(fwdB), .fwdC(fwdC), .fwdD(fwdD)
  );

  // expected ALU select from R1, R2, R4, R5, R6, R7
  function automatic logic [1:0] aluExp(logic [REG_W-1:0] src);
    if (memRegWrite && memRd != 0 && memRd == src) return 2'b10;
    if (wbRegWrite && wbRd != 0 && wbRd == src) return 2'b01;
    return 2'b00;
  endfunction

  // expected comparator select from R8, R9
  function automatic logic brExp(logic [REG_W-1:0] src);
    return idBranch && memRd != 0 && memRd == src;
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(logic [REG_W-1:0] rs, logic [REG_W-1:0] rt,
                       logic [REG_W-1:0] mrd, logic mwe,
                       logic [REG_W-1:0] wrd, logic wwe,
                       logic [REG_W-1:0] irs, logic [REG_W-1:0] irt, logic br);
    @(posedge clk);
    exRs = rs; exRt = rt; memRd = mrd; memRegWrite = mwe;
    wbRd = wrd; wbRegWrite = wwe; idRs = irs; idRt = irt; idBranch = br;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] wbVal, memVal, regVal, opA;
    void'($urandom(32'd20240611));

    // quiet state: nothing writes
    drive(1, 2, 0, 0, 0, 0, 3, 4, 0);
    check("R1 idle fwdA", fwdA, 2'b00);
    check("R1 idle fwdB", fwdB, 2'b00);
    check("R9 idle fwdC", {1'b0, fwdC}, 2'b00);

    // R2/R3: memory stage feeds both operands at once
    drive(7, 7, 7, 1, 0, 0, 0, 0, 0);
    check("R2 mem to A", fwdA, 2'b10);
    check("R3 mem to B same cycle", fwdB, 2'b10);

    // R3: A from memory stage, B from write-back independently
    drive(5, 9, 5, 1, 9, 1, 0, 0, 0);
    check("R3 A mem", fwdA, 2'b10);
    check("R3 B wb", fwdB, 2'b01);

    // R4: write-back only
    drive(12, 3, 20, 1, 12, 1, 0, 0, 0);
    check("R4 wb to A", fwdA, 2'b01);
    check("R4 no match B", fwdB, 2'b00);

    // R5: both stages write the same register
    drive(4, 4, 4, 1, 4, 1, 0, 0, 0);
    check("R5 priority A", fwdA, 2'b10);
    check("R5 priority B", fwdB, 2'b10);

    // R6: memory stage matches but does not write
    drive(6, 6, 6, 0, 6, 1, 0, 0, 0);
    check("R6 wb passes A", fwdA, 2'b01);
    check("R6 wb passes B", fwdB, 2'b01);

    // R7: register 0
    drive(0, 0, 0, 1, 0, 1, 0, 0, 1);
    check("R7 zero A", fwdA, 2'b00);
    check("R7 zero B", fwdB, 2'b00);
    check("R7 zero C/D", {fwdC, fwdD}, 2'b00);

    // R8: branch forward regardless of memRegWrite
    drive(0, 0, 8, 0, 0, 0, 8, 2, 1);
    check("R8 C without write enable", {1'b0, fwdC}, 2'b01);
    check("R8 D no match", {1'b0, fwdD}, 2'b00);
    drive(0, 0, 11, 1, 0, 0, 1, 11, 1);
    check("R8 D match", {fwdC, fwdD}, 2'b01);

    // R9: no branch, and write-back never feeds the comparator
    drive(0, 0, 8, 1, 0, 0, 8, 8, 0);
    check("R9 not branch", {fwdC, fwdD}, 2'b00);
    drive(0, 0, 3, 1, 9, 1, 9, 9, 1);
    check("R9 wb ignored", {fwdC, fwdD}, 2'b00);

    // R10: add $1,$1,$2 ; add $1,$1,$3 ; add $1,$1,$4 with $1=10,$2=1,$3=2,$4=3
    regVal = 10; memVal = 13; wbVal = 11;
    drive(1, 4, 1, 1, 1, 1, 0, 0, 0);
    check("R10 chain fwdA", fwdA, 2'b10);
    check("R10 chain fwdB", fwdB, 2'b00);
    opA = (fwdA == 2'b10) ? memVal : (fwdA == 2'b01) ? wbVal : regVal;
    checks++;
    if (opA != 32'd13) begin
      errors++;
      $display("FAIL R10 operand: actual %0d expected 13", opA);
    end

    // random traffic over a narrow register range
    for (int n = 0; n < 3000; n++) begin
      drive($urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(3, 0), 1'($urandom_range(1, 0)),
            $urandom_range(3, 0), 1'($urandom_range(1, 0)), $urandom_range(3, 0), $urandom_range(3, 0),
            1'($urandom_range(1, 0)));
      check("R2 R4 R5 random fwdA", fwdA, aluExp(exRs));
      check("R3 R6 random fwdB", fwdB, aluExp(exRt));
      check("R8 random fwdC", {1'b0, fwdC}, {1'b0, brExp(idRs)});
      check("R9 random fwdD", {1'b0, fwdD}, {1'b0, brExp(idRt)});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule